// File: doc/BRIEF.md
# Dual-Block Banked Prediction Read Stage

This block delivers branch predictions for two successive fetch blocks in every cycle from a predictor that is split into four banks, each built from single-ported memories. Each bank holds four logical tables: a bimodal table and three global tables, called G0, G1 and Meta here. The block picks a bank for each fetch block from the addresses of earlier blocks. It does this from registered state, so the choice is ready at the start of the request cycle. The rule ensures that a block never uses the same bank as the block just before it. As a result, the two reads in one cycle never collide and no stall or arbitration is needed.

Inside the chosen bank, a row is formed from a wordline part and a column part. The wordline part is built without hashing from four history bits and two address bits, and all tables share it. Each column bit is at most one two-input XOR. Every table returns one 8-bit word, which holds the predictions for all eight instruction slots of the block. The word then passes through an XOR permutation. Its 3-bit key folds long history and the upper address bits. A fill port, used only while no lookup is pending, loads the arrays. Training updates are handled elsewhere.

Top module: `dual_bank_pred_read`

## Requirements
- R1: For an accepted pair, the bank of block 0 is bits 6:5 of the block-0 address of the previous accepted pair, incremented modulo 4 if that value equals the bank of the previous block 1. The bank of block 1 is bits 6:5 of the previous block-1 address, incremented modulo 4 if that value equals the bank just chosen for block 0.
- R2: After reset, the stored prior address fields and the prior bank are zero, so a first pair always gets bank 1 for block 0 and bank 0 for block 1.
- R3: The two banks of one pair differ, and the block-0 bank differs from the block-1 bank of the previous accepted pair.
- R4: A request with `req_valid` high in cycle n raises `rd_valid` in cycle n+1, together with the banks and words for that request.
- R5: The 6-bit wordline is {h[3:0], a[8], a[7]} with h3 as the most significant bit. The table row is {column, wordline}, with the wordline in the low six bits.
- R6: Column bit j is a[9+j] for the bimodal table, a[9+j]^h[4+j] for G0, a[9+j]^h[10+j] for G1 and a[9+j]^h[7+j] for Meta. By default the bimodal table has 1 column bit and the others have 2.
- R7: Output bit j of a table word is raw bit j XOR k. Key bit b is the XOR of h[i] for i below the table's history length with i mod 3 = b, XORed with a[i] for 9 <= i < 32 with i mod 3 = b. The history lengths are 4 (bimodal), 13 (G0), 21 (G1) and 15 (Meta).
- R8: Each output carries the words as {Meta, G1, G0, bimodal} from bit 31 down to bit 0. Table codes on the fill port are 0 for bimodal, 1 for G0, 2 for G1 and 3 for Meta.
- R9: With `fill_en` high and `req_valid` low, `fill_data` is written into bank `fill_bank`, table `fill_tbl`, row `fill_row`. The bimodal table uses only the low seven row bits.
- R10: A fill presented while `req_valid` is high is dropped and leaves the array unchanged.
- R11: A cycle with `req_valid` low leaves the bank state unchanged and produces `rd_valid` low in the next cycle.
- R12: While reset is asserted, `rd_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A pair of fetch blocks is presented |
| blk0_addr | input | 27 | Block 0 address bits 31:5 |
| blk0_hist | input | 21 | Compressed history for block 0 |
| blk1_addr | input | 27 | Block 1 address bits 31:5 |
| blk1_hist | input | 21 | Compressed history for block 1 |
| fill_en | input | 1 | Array load request |
| fill_bank | input | 2 | Bank to load |
| fill_tbl | input | 2 | Table code to load |
| fill_row | input | 8 | Row to load, {column, wordline} |
| fill_data | input | 8 | Word to load |
| rd_valid | output | 1 | Results of the previous cycle's pair are valid |
| rd0_bank | output | 2 | Bank used by block 0 |
| rd1_bank | output | 2 | Bank used by block 1 |
| rd0_words | output | 32 | Permuted words for block 0 |
| rd1_words | output | 32 | Permuted words for block 1 |

## Verification
The bench targets the bank-collision cases, where the seed from bits 6:5 equals the preceding bank and must wrap from 3 to 0. It sweeps every pairing of seed fields back to back and also across idle gaps. An off-by-one here shows up as two reads in one bank or as words fetched from the wrong bank. A full sweep of the wordline inputs and random histories exposes a swapped wordline or column bit, a mis-folded key or a wrong table order, because each shows up as a wrong word. Targeted fills, one made during a lookup and one made while idle, show whether a design writes through a busy port or drops a legal load.

// File: rtl/dbpr_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the dual-block prediction read stage.
package dbpr_pkg;
    localparam int NBANK   = 4;
    localparam int BANK_W  = 2;
    localparam int WORD_W  = 8;
    localparam int NTAB    = 4;
    localparam int WL_BITS = 6;
    localparam int ACOL    = 9;   // first address bit used for columns and keys

    typedef enum logic [1:0] {
        TBL_BIM  = 2'd0,
        TBL_G0   = 2'd1,
        TBL_G1   = 2'd2,
        TBL_META = 2'd3
    } tbl_e;

    // Take the seed bank, stepping past the bank to avoid.
    function automatic logic [BANK_W-1:0] pick_bank(input logic [BANK_W-1:0] seed,
                                                    input logic [BANK_W-1:0] avoid);
        return (seed == avoid) ? seed + 2'd1 : seed;
    endfunction

    // XOR permutation: output bit j takes raw bit j^k.
    function automatic logic [WORD_W-1:0] unshuffle(input logic [WORD_W-1:0] w,
                                                    input logic [2:0] k);
        logic [WORD_W-1:0] o;
        for (int j = 0; j < WORD_W; j++) o[j] = w[3'(j) ^ k];
        return o;
    endfunction
endpackage

// File: rtl/dbpr_bank_sched.sv
`timescale 1ns/1ps
// Bank scheduler. Picks the banks for the incoming pair from registered
// fields of the previous accepted pair, so no logic sits ahead of the arrays
// beyond a 2-bit compare. Assumes both blocks of a pair are accepted together.
module dbpr_bank_sched
    import dbpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] seed0,     // bits 6:5 of block 0 address
    input  logic [BANK_W-1:0] seed1,     // bits 6:5 of block 1 address
    output logic [BANK_W-1:0] bank0,
    output logic [BANK_W-1:0] bank1
);
    logic [BANK_W-1:0] y_seed_q, z_seed_q, z_bank_q;

    // Chain the choice: block 0 avoids the last block 1, block 1 avoids block 0.
    always_comb begin
        bank0 = pick_bank(y_seed_q, z_bank_q);
        bank1 = pick_bank(z_seed_q, bank0);
    end

    // Remember seeds and last bank of the latest accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_seed_q <= '0;
            z_seed_q <= '0;
            z_bank_q <= '0;
        end else if (req_valid) begin
            y_seed_q <= seed0;
            z_seed_q <= seed1;
            z_bank_q <= bank1;
        end
    end
endmodule

// File: rtl/dbpr_index.sv
`timescale 1ns/1ps
// Index former for one fetch block. Produces the row of each table
// ({column, wordline}) and the 3-bit permutation key of each table.
// Assumes the history base of each column stays inside HIST_W.
module dbpr_index
    import dbpr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HIST_W     = 21,
    parameter int G_COL_BITS = 2,
    parameter int B_COL_BITS = 1,
    parameter int HLEN_BIM   = 4,
    parameter int HLEN_G0    = 13,
    parameter int HLEN_G1    = 21,
    parameter int HLEN_META  = 15,
    parameter int HCB_G0     = 4,
    parameter int HCB_G1     = 10,
    parameter int HCB_META   = 7,
    localparam int ROW_W     = WL_BITS + G_COL_BITS,
    localparam int BROW_W    = WL_BITS + B_COL_BITS
) (
    input  logic [ADDR_W-1:7]            addr_hi,
    input  logic [HIST_W-1:0]            hist,
    output logic [BROW_W-1:0]            bim_row,
    output logic [NTAB-2:0][ROW_W-1:0]   g_rows,   // G0, G1, Meta
    output logic [NTAB-1:0][2:0]         keys
);
    logic [WL_BITS-1:0]    wl;
    logic [B_COL_BITS-1:0] bcol;

    // Fold history up to len and the upper address bits into a 3-bit key.
    function automatic logic [2:0] fold_key(input logic [HIST_W-1:0] h,
                                            input int len,
                                            input logic [ADDR_W-1:7] a);
        logic [2:0] k;
        k = '0;
        for (int i = 0; i < HIST_W; i++)
            if (i < len) k[i % 3] ^= h[i];
        for (int i = ACOL; i < ADDR_W; i++) k[i % 3] ^= a[i];
        return k;
    endfunction

    // Unhashed wordline shared by all tables.
    assign wl = {hist[3:0], addr_hi[8], addr_hi[7]};

    // Bimodal column straight from address bits.
    for (genvar j = 0; j < B_COL_BITS; j++) begin : g_bcol
        assign bcol[j] = addr_hi[ACOL + j];
    end
    assign bim_row = {bcol, wl};
    assign keys[0] = fold_key(hist, HLEN_BIM, addr_hi);

    // Global tables: one two-input XOR per column bit.
    for (genvar t = 1; t < NTAB; t++) begin : g_tab
        localparam int HB = (t == 1) ? HCB_G0 : (t == 2) ? HCB_G1 : HCB_META;
        localparam int HL = (t == 1) ? HLEN_G0 : (t == 2) ? HLEN_G1 : HLEN_META;
        logic [G_COL_BITS-1:0] col;
        for (genvar j = 0; j < G_COL_BITS; j++) begin : g_col
            assign col[j] = addr_hi[ACOL + j] ^ hist[HB + j];
        end
        assign g_rows[t-1] = {col, wl};
        assign keys[t]     = fold_key(hist, HL, addr_hi);
    end
endmodule

// File: rtl/dbpr_sram.sv
`timescale 1ns/1ps
// Single-ported word array: one read or one write per cycle, registered
// read data. Assumes the caller never asks for both in one cycle.
module dbpr_sram
    import dbpr_pkg::*;
#(
    parameter int ADDR_BITS = 8,
    localparam int DEPTH    = 1 << ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Storage write on the single port.
    always_ff @(posedge clk) begin
        if (en && we) mem[addr] <= wdata;
    end

    // Registered read on the single port.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (en && !we)  rdata <= mem[addr];
    end
endmodule

// File: rtl/dual_bank_pred_read.sv
`timescale 1ns/1ps
// Dual-block prediction read stage. Two fetch blocks per cycle are steered
// to distinct banks of four single-ported banks, each holding four tables;
// results come one cycle later after the per-table XOR permutation.
// Assumes fills are issued only in cycles with no lookup (others are dropped).
module dual_bank_pred_read
    import dbpr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HIST_W     = 21,
    parameter int G_COL_BITS = 2,
    parameter int B_COL_BITS = 1,
    localparam int ROW_W     = WL_BITS + G_COL_BITS,
    localparam int BROW_W    = WL_BITS + B_COL_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:5]      blk0_addr,
    input  logic [HIST_W-1:0]      blk0_hist,
    input  logic [ADDR_W-1:5]      blk1_addr,
    input  logic [HIST_W-1:0]      blk1_hist,
    input  logic                   fill_en,
    input  logic [BANK_W-1:0]      fill_bank,
    input  logic [1:0]             fill_tbl,
    input  logic [ROW_W-1:0]       fill_row,
    input  logic [WORD_W-1:0]      fill_data,
    output logic                   rd_valid,
    output logic [BANK_W-1:0]      rd0_bank,
    output logic [BANK_W-1:0]      rd1_bank,
    output logic [NTAB*WORD_W-1:0] rd0_words,
    output logic [NTAB*WORD_W-1:0] rd1_words
);
    logic [1:0][ADDR_W-1:5]          baddr;
    logic [1:0][HIST_W-1:0]          bhist;
    logic [1:0][BROW_W-1:0]          bim_row;
    logic [1:0][NTAB-2:0][ROW_W-1:0] g_rows;
    logic [1:0][NTAB-1:0][2:0]       keys;
    logic [1:0][NTAB-1:0][2:0]       key_q;
    logic [BANK_W-1:0]               bank0, bank1;
    logic [1:0][BANK_W-1:0]          bank_q;
    logic                            v_q;
    logic                            fill_go;
    logic [NBANK*NTAB-1:0]           we_vec;
    logic [WORD_W-1:0]               dout [NBANK][NTAB];

    assign baddr   = {blk1_addr, blk0_addr};
    assign bhist   = {blk1_hist, blk0_hist};
    assign fill_go = fill_en && !req_valid;

    dbpr_bank_sched u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .seed0    (blk0_addr[6:5]),
        .seed1    (blk1_addr[6:5]),
        .bank0    (bank0),
        .bank1    (bank1)
    );

    // One index former per fetch block.
    for (genvar k = 0; k < 2; k++) begin : g_blk
        dbpr_index #(
            .ADDR_W    (ADDR_W),
            .HIST_W    (HIST_W),
            .G_COL_BITS(G_COL_BITS),
            .B_COL_BITS(B_COL_BITS)
        ) u_idx (
            .addr_hi(baddr[k][ADDR_W-1:7]),
            .hist   (bhist[k]),
            .bim_row(bim_row[k]),
            .g_rows (g_rows[k]),
            .keys   (keys[k])
        );
    end

    // Array of banks x tables; each port serves the block steered to it, or a fill.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar t = 0; t < NTAB; t++) begin : g_tbl
            localparam int DB = (t == 0) ? BROW_W : ROW_W;
            logic          sel0, sel1, we;
            logic [DB-1:0] rd_row, a;
            if (t == 0) begin : g_b
                assign rd_row = sel0 ? bim_row[0] : bim_row[1];
            end else begin : g_g
                assign rd_row = sel0 ? g_rows[0][t-1] : g_rows[1][t-1];
            end
            assign sel0 = req_valid && (bank0 == BANK_W'(b));
            assign sel1 = req_valid && (bank1 == BANK_W'(b));
            assign we   = fill_go && (fill_bank == BANK_W'(b)) && (fill_tbl == 2'(t));
            assign a    = we ? fill_row[DB-1:0] : rd_row;
            assign we_vec[b*NTAB + t] = we;

            dbpr_sram #(.ADDR_BITS(DB)) u_mem (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (sel0 || sel1 || we),
                .we   (we),
                .addr (a),
                .wdata(fill_data),
                .rdata(dout[b][t])
            );
        end
    end

    // Hold banks and keys of the pair whose arrays are being read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            bank_q <= '0;
            key_q  <= '0;
        end else begin
            v_q <= req_valid;
            if (req_valid) begin
                bank_q <= {bank1, bank0};
                key_q  <= keys;
            end
        end
    end

    // Route each block's bank data out through its permutation.
    always_comb begin
        for (int t = 0; t < NTAB; t++) begin
            rd0_words[t*WORD_W +: WORD_W] = unshuffle(dout[bank_q[0]][t], key_q[0][t]);
            rd1_words[t*WORD_W +: WORD_W] = unshuffle(dout[bank_q[1]][t], key_q[1][t]);
        end
    end

    assign rd_valid = v_q;
    assign rd0_bank = bank_q[0];
    assign rd1_bank = bank_q[1];

    assert_banks_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (bank0 != bank1));
    assert_chain_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> (bank0 != $past(bank1)));
    assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rd_valid);
    assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rd_valid);
    assert_fill_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && req_valid) |-> ($countones(we_vec) == 0));
    assert_fill_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));
    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);
    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && rd_valid) |=> (rd0_bank == $past(rd0_bank)));
endmodule

// File: tb/dual_bank_pred_read_tb.sv
`timescale 1ns/1ps
module dual_bank_pred_read_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:5] blk0_addr = '0, blk1_addr = '0;
    logic [20:0] blk0_hist = '0, blk1_hist = '0;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_bank = '0, fill_tbl = '0;
    logic [7:0]  fill_row = '0, fill_data = '0;
    logic        rd_valid;
    logic [1:0]  rd0_bank, rd1_bank;
    logic [31:0] rd0_words, rd1_words;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dual_bank_pred_read u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .blk0_addr(blk0_addr), .blk0_hist(blk0_hist),
        .blk1_addr(blk1_addr), .blk1_hist(blk1_hist),
        .fill_en(fill_en), .fill_bank(fill_bank), .fill_tbl(fill_tbl),
        .fill_row(fill_row), .fill_data(fill_data),
        .rd_valid(rd_valid), .rd0_bank(rd0_bank), .rd1_bank(rd1_bank),
        .rd0_words(rd0_words), .rd1_words(rd1_words)
    );

    // Bench-side bank state and pending expectation.
    logic [1:0]  m_y = '0, m_z = '0, m_zb = '0;
    logic        p_v = 1'b0;
    logic [1:0]  p_b0, p_b1;
    logic [31:0] p_w0, p_w1;
    string       p_tag;
    logic        have_last = 1'b0;
    logic [1:0]  last_b1;
    // One tracked array entry that differs from the fill pattern.
    logic        ov_v = 1'b0;
    int          ov_b, ov_t, ov_r;
    logic [7:0]  ov_d;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] pick(input logic [1:0] s, input logic [1:0] av);
        return (s == av) ? 2'(s + 2'd1) : s;
    endfunction

    function automatic logic [7:0] pat(input int b, input int t, input int r);
        return 8'((b * 61 + t * 29 + r * 7 + (r >> 3) * 5) ^ (r * 3));
    endfunction

    // R5 and R6: row = {column, wordline}
    function automatic int exp_row(input int t, input logic [31:0] a, input logic [20:0] h);
        int wl, col;
        wl = {h[3:0], a[8], a[7]};
        case (t)
            0:       col = a[9];
            1:       col = {a[10] ^ h[5],  a[9] ^ h[4]};
            2:       col = {a[10] ^ h[11], a[9] ^ h[10]};
            default: col = {a[10] ^ h[8],  a[9] ^ h[7]};
        endcase
        return col * 64 + wl;
    endfunction

    // R7 key
    function automatic logic [2:0] exp_key(input int t, input logic [31:0] a, input logic [20:0] h);
        int len;
        logic [2:0] k;
        len = (t == 0) ? 4 : (t == 1) ? 13 : (t == 2) ? 21 : 15;
        k = '0;
        for (int i = 0; i < len; i++) k[i % 3] = k[i % 3] ^ h[i];
        for (int i = 9; i < 32; i++) k[i % 3] = k[i % 3] ^ a[i];
        return k;
    endfunction

    // R8 packing of the four permuted words
    function automatic logic [31:0] exp_words(input int b, input logic [31:0] a, input logic [20:0] h);
        logic [31:0] w;
        for (int t = 0; t < 4; t++) begin
            int r;
            logic [7:0] d;
            logic [2:0] k;
            r = exp_row(t, a, h);
            d = (ov_v && ov_b == b && ov_t == t && ov_r == r) ? ov_d : pat(b, t, r);
            k = exp_key(t, a, h);
            for (int j = 0; j < 8; j++) w[t*8 + j] = d[3'(j) ^ k];
        end
        return w;
    endfunction

    // One cycle: check what the previous cycle produced, then drive this one.
    task automatic step(input logic v, input logic [31:0] a0, input logic [20:0] h0,
                        input logic [31:0] a1, input logic [20:0] h1,
                        input logic fe, input logic [1:0] fb, input logic [1:0] ft,
                        input int fr, input logic [7:0] fd, input string tag);
        @(negedge clk);
        if (p_v) begin
            chk(rd_valid == 1'b1, "R4 valid after request", 32'(rd_valid), 1);
            chk(rd0_bank == p_b0, {p_tag, " R1 bank0"}, 32'(rd0_bank), 32'(p_b0));
            chk(rd1_bank == p_b1, {p_tag, " R1 bank1"}, 32'(rd1_bank), 32'(p_b1));
            chk(rd0_bank != rd1_bank, "R3 pair banks differ", 32'(rd0_bank), 32'(rd1_bank));
            if (have_last)
                chk(rd0_bank != last_b1, "R3 chained banks differ", 32'(rd0_bank), 32'(last_b1));
            last_b1   = rd1_bank;
            have_last = 1'b1;
            chk(rd0_words == p_w0, {p_tag, " R5/R6/R7/R8 block0 words"}, rd0_words, p_w0);
            chk(rd1_words == p_w1, {p_tag, " R5/R6/R7/R8 block1 words"}, rd1_words, p_w1);
        end else begin
            chk(rd_valid == 1'b0, "R11 idle gives no valid", 32'(rd_valid), 0);
        end
        req_valid = v;
        blk0_addr = a0[31:5]; blk0_hist = h0;
        blk1_addr = a1[31:5]; blk1_hist = h1;
        fill_en = fe; fill_bank = fb; fill_tbl = ft; fill_row = 8'(fr); fill_data = fd;
        if (v) begin
            p_b0 = pick(m_y, m_zb);
            p_b1 = pick(m_z, p_b0);
            p_w0 = exp_words(p_b0, a0, h0);
            p_w1 = exp_words(p_b1, a1, h1);
            p_tag = tag;
            m_y = a0[6:5]; m_z = a1[6:5]; m_zb = p_b1;
        end else if (fe) begin
            ov_v = 1'b1; ov_b = fb; ov_t = ft;
            ov_r = (ft == 2'd0) ? (fr & 127) : fr;
            ov_d = fd;
        end
        p_v = v;
    endtask

    task automatic pair(input logic [31:0] a0, input logic [20:0] h0,
                        input logic [31:0] a1, input logic [20:0] h1, input string tag);
        step(1'b1, a0, h0, a1, h1, 1'b0, 2'd0, 2'd0, 0, 8'd0, tag);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 0, 1'b0, 2'd0, 2'd0, 0, 8'd0, "idle");
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] qa0, qa1, pa0, pa1, ra0;
        logic [20:0] qh0, qh1, ph0, ph1, rh0;
        logic [1:0]  b0, b1, qb0;
        int          qr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R12 reset clears valid", 32'(rd_valid), 0);
        rst_n = 1'b1;

        // R9: load every entry with the pattern while idle.
        for (int b = 0; b < 4; b++)
            for (int t = 0; t < 4; t++)
                for (int r = 0; r < ((t == 0) ? 128 : 256); r++)
                    step(1'b0, 0, 0, 0, 0, 1'b1, 2'(b), 2'(t), r, pat(b, t, r), "fill");

        // R2: first pair after reset with zero seeds.
        pair(32'h0000_0000, 21'h0_1234, 32'h0000_0000, 21'h1_0F0F, "R2 first pair");
        idle();
        chk(rd0_bank == 2'd1, "R2 first bank0", 32'(rd0_bank), 1);
        chk(rd1_bank == 2'd0, "R2 first bank1", 32'(rd1_bank), 0);

        // R1: every seed pairing, back to back and across gaps.
        for (int i = 0; i < 48; i++) begin
            logic [31:0] x0, x1;
            x0 = ($urandom & 32'hFFFF_FF9F) | (32'((i >> 2) & 3) << 5);
            x1 = ($urandom & 32'hFFFF_FF9F) | (32'(i & 3) << 5);
            pair(x0, 21'($urandom), x1, 21'($urandom), "R1 seed sweep");
            if (i % 7 == 3) idle();
        end

        // R5: every wordline input combination.
        for (int i = 0; i < 64; i++) begin
            logic [31:0] x0, x1;
            logic [20:0] g0, g1;
            x0 = ($urandom & 32'hFFFF_FE7F) | (32'(i & 3) << 7);
            g0 = (21'($urandom) & 21'h1F_FFF0) | 21'((i >> 2) & 15);
            x1 = ($urandom & 32'hFFFF_FE7F) | (32'((i + 1) & 3) << 7);
            g1 = (21'($urandom) & 21'h1F_FFF0) | 21'(((i + 5) >> 2) & 15);
            pair(x0, g0, x1, g1, "R5 wordline sweep");
        end

        // R10: a fill during a lookup is dropped; the next lookup reads that entry.
        pa0 = $urandom; pa1 = $urandom; ph0 = 21'($urandom); ph1 = 21'($urandom);
        qa0 = $urandom; qa1 = $urandom; qh0 = 21'($urandom); qh1 = 21'($urandom);
        b0 = pick(m_y, m_zb);
        b1 = pick(m_z, b0);
        qb0 = pick(pa0[6:5], b1);
        qr = exp_row(1, qa0, qh0);
        step(1'b1, pa0, ph0, pa1, ph1, 1'b1, qb0, 2'd1, qr, ~pat(qb0, 1, qr), "R10 busy fill");
        pair(qa0, qh0, qa1, qh1, "R10 entry unchanged");

        // R9: a fill while idle lands; the next lookup reads it.
        ra0 = $urandom; rh0 = 21'($urandom);
        qb0 = pick(m_y, m_zb);
        qr = exp_row(3, ra0, rh0);
        step(1'b0, 0, 0, 0, 0, 1'b1, qb0, 2'd3, qr, ~pat(int'(qb0), 3, qr), "R9 idle fill");
        pair(ra0, rh0, $urandom, 21'($urandom), "R9 entry loaded");

        // R3 and R11: random streams with idle gaps.
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 5) == 0) idle();
            else pair($urandom, 21'($urandom), $urandom, 21'($urandom), "R3 random");
        end
        idle();
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule